// File: doc/BRIEF.md
# Receive-Level Flow Character Inserter

This block throttles a remote sender by placing the two in-band flow-control characters into the local transmit stream. It watches the fill level of the local receive FIFO. When the FIFO is close to full, it sends the "stop" character. When the FIFO has drained again, it sends the "resume" character. Between the two thresholds there is a dead band, so the block does not toggle on small changes in level.

The block sits between the transmit FIFO and the transmit shift register. At every character boundary it decides which byte the shift register takes next:
- A flow character that is due takes priority.
- Otherwise the byte at the head of the transmit FIFO is taken, and that FIFO is popped.

A character that the shift register has already taken always completes, because the block only chooses at the next boundary. Bytes in the transmit FIFO are never altered. They are sent after the flow character.

The block keeps a record of any stop character that no resume character has rescinded yet. It also reports which flow character was sent last. Turning off the automatic mode clears the record and never produces a resume character.

**Stream rules for the output.**
- The output is a valid/ready stream. The shift register drives `sh_ready` high on the cycles when it can load a new character.
- A byte is transferred on a cycle where both `sh_valid` and `sh_ready` are high. That cycle is the moment the character starts to transmit.
- While `sh_ready` is low, the offer is not held. `sh_valid`, `sh_data` and `sh_is_flow` may change or drop. This is how a flow character whose cause has gone away is withdrawn before it starts.

**Transmit FIFO side.**
- The transmit FIFO presents its head byte through `txq_data` and `txq_nonempty`.
- The FIFO is popped by `txq_pop`, which is high only on a transfer cycle.

Top module: `flowins_top`

## Requirements
- R1: After reset, `xoff_outstanding` is 0, `last_is_xoff` is 0, `txq_pop` is 0, and `sh_valid` is 0 while the transmit FIFO is empty.
- R2: The stop condition is a receive level greater than 12, as sampled at the previous clock edge, with auto mode on and no stop outstanding. When it holds, the block offers the stop code with `sh_is_flow`=1. Once that stop character is transferred, `xoff_outstanding`=1 and `last_is_xoff`=1 from the next cycle.
- R3: The resume condition is a receive level lower than 8, as sampled at the previous clock edge, with a stop outstanding. When it holds, the block offers the resume code with `sh_is_flow`=1. Once that resume character is transferred, `xoff_outstanding`=0 and `last_is_xoff`=0 from the next cycle.
- R4: Levels from 8 to 12 inclusive never cause a flow character to be offered, whatever the outstanding state.
- R5: While a flow character is offered, `txq_pop` is 0 and no queued byte is offered. Queued bytes follow, unchanged and in order, after the flow character has been transferred.
- R6: With no flow character due, `sh_valid` equals `txq_nonempty` and `sh_data` equals `txq_data`. `txq_pop` is high only on a cycle with `sh_valid`, `sh_ready` and `txq_nonempty` all high.
- R7: If the level returns into the band 8 to 12 before the offered flow character is transferred, the offer is withdrawn. That character is never sent.
- R8: No stop character is offered while one is outstanding. No resume character is offered unless a stop is outstanding.
- R9: With `auto_rx_en`=0, no flow character is offered, and `xoff_outstanding` is 0 from the next cycle. No resume character is sent as a result. `last_is_xoff` keeps its value.
- R10: The flow byte placed on `sh_data` is the value of `xoff_code` or `xon_code` in the cycle it is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| auto_rx_en | input | 1 | Auto-receiver flow mode enable; 0 clears the outstanding-stop record |
| rx_level | input | LVL_W (5) | Receive FIFO fill level |
| xon_code | input | 8 | Resume character code |
| xoff_code | input | 8 | Stop character code |
| txq_nonempty | input | 1 | Transmit FIFO holds at least one byte |
| txq_data | input | 8 | Transmit FIFO head byte |
| txq_pop | output | 1 | Pop the transmit FIFO head |
| sh_valid | output | 1 | A byte is offered to the shift register |
| sh_ready | input | 1 | Shift register can load a new character this cycle |
| sh_data | output | 8 | Offered byte |
| sh_is_flow | output | 1 | Offered byte is a flow character |
| last_is_xoff | output | 1 | Last flow character sent was the stop code (0: resume, or none since reset) |
| xoff_outstanding | output | 1 | A stop character has been sent and not yet rescinded |

## Verification
The main function is tried with four kinds of level pattern:
- **Rising above 12.** Tells a correct stop decision apart from a threshold that is off by one.
- **Parking at exactly 8 and exactly 12.** Tells the dead band apart from a plain single-threshold compare.
- **Falling below 8 with and without a stop outstanding.** Tells the resume condition apart from a level-only trigger.
- **A level excursion that reverses while the shift register is busy.** Tells withdrawal apart from a latched request.

A scoreboard of expected bytes shows the ordering of flow characters against queued data. It also shows that withdrawn or suppressed characters never appear. Switching the mode off with a stop outstanding tells clearing of the record apart from sending a resume character.

// File: rtl/flowins_pkg.sv
package flowins_pkg;

  // Which flow character, if any, the tracker is asking for.
  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_XOFF = 2'd1,
    FC_XON  = 2'd2
  } fc_req_e;

  localparam int unsigned CHAR_W = 8;

  function automatic logic fc_is_flow(input fc_req_e r);
    return r != FC_NONE;
  endfunction

endpackage

// File: rtl/flowins_thresh.sv
module flowins_thresh #(
  parameter int unsigned LVL_W   = 5,
  parameter int unsigned HI_TH   = 12,
  parameter int unsigned LO_TH   = 8,
  parameter bit          REG_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  output logic             above_hi,
  output logic             below_lo
);

  localparam logic [LVL_W-1:0] HI_V = LVL_W'(HI_TH);
  localparam logic [LVL_W-1:0] LO_V = LVL_W'(LO_TH);

  logic above_c, below_c;

  assign above_c = level > HI_V;
  assign below_c = level < LO_V;

  generate
    if (REG_CMP) begin : g_reg
      // Registered compare: decisions use the level seen at the last edge.
      logic above_q, below_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          above_q <= 1'b0;
          below_q <= 1'b0;
        end else begin
          above_q <= above_c;
          below_q <= below_c;
        end
      end
      assign above_hi = above_q;
      assign below_lo = below_q;
    end else begin : g_comb
      assign above_hi = above_c;
      assign below_lo = below_c;
    end
  endgenerate

endmodule

// File: rtl/flowins_track.sv
module flowins_track
  import flowins_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    auto_en,
  input  logic    above_hi,
  input  logic    below_lo,
  input  logic    sent_xoff,
  input  logic    sent_xon,
  output fc_req_e req,
  output logic    outstanding,
  output logic    last_xoff
);

  logic out_q, last_q;

  // The request is recomputed every cycle, so a condition that clears
  // simply withdraws it.
  always_comb begin
    req = FC_NONE;
    if (auto_en) begin
      if (above_hi && !out_q)     req = FC_XOFF;
      else if (below_lo && out_q) req = FC_XON;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      if (!auto_en)       out_q <= 1'b0;
      else if (sent_xoff) out_q <= 1'b1;
      else if (sent_xon)  out_q <= 1'b0;

      if (sent_xoff)     last_q <= 1'b1;
      else if (sent_xon) last_q <= 1'b0;
    end
  end

  assign outstanding = out_q;
  assign last_xoff   = last_q;

endmodule

// File: rtl/flowins_arb.sv
module flowins_arb
  import flowins_pkg::*;
(
  input  fc_req_e           req,
  input  logic [CHAR_W-1:0] xon_code,
  input  logic [CHAR_W-1:0] xoff_code,
  input  logic              txq_nonempty,
  input  logic [CHAR_W-1:0] txq_data,
  input  logic              sh_ready,
  output logic              sh_valid,
  output logic [CHAR_W-1:0] sh_data,
  output logic              sh_is_flow,
  output logic              txq_pop,
  output logic              sent_xoff,
  output logic              sent_xon
);

  logic flow;

  assign flow = fc_is_flow(req);

  always_comb begin
    sh_is_flow = flow;
    sh_valid   = flow || txq_nonempty;
    unique case (req)
      FC_XOFF: sh_data = xoff_code;
      FC_XON:  sh_data = xon_code;
      default: sh_data = txq_data;
    endcase
  end

  assign txq_pop   = sh_ready && txq_nonempty && !flow;
  assign sent_xoff = sh_ready && (req == FC_XOFF);
  assign sent_xon  = sh_ready && (req == FC_XON);

endmodule

// File: rtl/flowins_top.sv
module flowins_top
  import flowins_pkg::*;
#(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned HI_TH = 12,
  parameter int unsigned LO_TH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_rx_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [7:0]       xon_code,
  input  logic [7:0]       xoff_code,
  input  logic             txq_nonempty,
  input  logic [7:0]       txq_data,
  output logic             txq_pop,
  output logic             sh_valid,
  input  logic             sh_ready,
  output logic [7:0]       sh_data,
  output logic             sh_is_flow,
  output logic             last_is_xoff,
  output logic             xoff_outstanding
);

  logic    above_hi, below_lo;
  logic    sent_xoff, sent_xon;
  fc_req_e req;

  flowins_thresh #(
    .LVL_W   (LVL_W),
    .HI_TH   (HI_TH),
    .LO_TH   (LO_TH),
    .REG_CMP (1'b1)
  ) u_thresh (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (rx_level),
    .above_hi (above_hi),
    .below_lo (below_lo)
  );

  flowins_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_en     (auto_rx_en),
    .above_hi    (above_hi),
    .below_lo    (below_lo),
    .sent_xoff   (sent_xoff),
    .sent_xon    (sent_xon),
    .req         (req),
    .outstanding (xoff_outstanding),
    .last_xoff   (last_is_xoff)
  );

  flowins_arb u_arb (
    .req          (req),
    .xon_code     (xon_code),
    .xoff_code    (xoff_code),
    .txq_nonempty (txq_nonempty),
    .txq_data     (txq_data),
    .sh_ready     (sh_ready),
    .sh_valid     (sh_valid),
    .sh_data      (sh_data),
    .sh_is_flow   (sh_is_flow),
    .txq_pop      (txq_pop),
    .sent_xoff    (sent_xoff),
    .sent_xon     (sent_xon)
  );

endmodule

// File: rtl/flowins_chk.sv
module flowins_chk #(
  parameter int unsigned LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             auto_rx_en,
  input logic [LVL_W-1:0] rx_level,
  input logic [7:0]       xon_code,
  input logic [7:0]       xoff_code,
  input logic             txq_nonempty,
  input logic             txq_pop,
  input logic             sh_valid,
  input logic             sh_ready,
  input logic [7:0]       sh_data,
  input logic             sh_is_flow,
  input logic             xoff_outstanding
);

  // R5
  flow_blocks_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_is_flow |-> !txq_pop);

  // R6
  pop_on_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> (sh_valid && sh_ready && txq_nonempty));

  // R2
  xoff_sets_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && sh_ready && sh_is_flow && auto_rx_en && !xoff_outstanding
     && sh_data == xoff_code && xon_code != xoff_code) |=> xoff_outstanding);

  // R8
  no_xon_unowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_is_flow && !xoff_outstanding) |-> sh_data == xoff_code);

  // R9
  mode_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rx_en |=> !xoff_outstanding);

  // R9
  mode_off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rx_en |-> !sh_is_flow);

  // R4
  band_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= LVL_W'(8) && rx_level <= LVL_W'(12))
      |=> ($past(rst_n) ? !sh_is_flow : 1'b1));

endmodule

bind flowins_top flowins_chk #(.LVL_W(LVL_W)) u_flowins_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .auto_rx_en       (auto_rx_en),
  .rx_level         (rx_level),
  .xon_code         (xon_code),
  .xoff_code        (xoff_code),
  .txq_nonempty     (txq_nonempty),
  .txq_pop          (txq_pop),
  .sh_valid         (sh_valid),
  .sh_ready         (sh_ready),
  .sh_data          (sh_data),
  .sh_is_flow       (sh_is_flow),
  .xoff_outstanding (xoff_outstanding)
);

// File: tb/flowins_top_tb_top.sv
module flowins_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_rx_en = 1'b1;
  logic [4:0] rx_level = '0;
  logic [7:0] xon_code = 8'h11;
  logic [7:0] xoff_code = 8'h13;
  logic       sh_ready = 1'b0;
  logic       txq_nonempty, txq_pop, sh_valid, sh_is_flow;
  logic       last_is_xoff, xoff_outstanding;
  logic [7:0] txq_data, sh_data;

  // Transmit FIFO model feeding the block.
  logic [7:0] qmem [16];
  int         wr_p = 0;
  int         rd_p = 0;

  assign txq_nonempty = (wr_p != rd_p);
  assign txq_data     = qmem[rd_p % 16];

  int checks = 0;
  int fails  = 0;

  logic [8:0] exp_q [$];

  always #5 clk = ~clk;

  flowins_top dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .auto_rx_en       (auto_rx_en),
    .rx_level         (rx_level),
    .xon_code         (xon_code),
    .xoff_code        (xoff_code),
    .txq_nonempty     (txq_nonempty),
    .txq_data         (txq_data),
    .txq_pop          (txq_pop),
    .sh_valid         (sh_valid),
    .sh_ready         (sh_ready),
    .sh_data          (sh_data),
    .sh_is_flow       (sh_is_flow),
    .last_is_xoff     (last_is_xoff),
    .xoff_outstanding (xoff_outstanding)
  );

  always @(posedge clk) begin
    if (txq_pop) rd_p <= rd_p + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: every transfer is compared against the scoreboard.
  always @(posedge clk) begin
    if (rst_n && sh_valid && sh_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7/R8 unexpected transfer", {sh_is_flow, sh_data}, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({sh_is_flow, sh_data} == e, "R5 transfer order", {sh_is_flow, sh_data}, e);
      end
    end
  end

  task automatic push_q(input logic [7:0] b);
    qmem[wr_p % 16] = b;
    wr_p = wr_p + 1;
  endtask

  task automatic expect_item(input logic flow, input logic [7:0] b);
    exp_q.push_back({flow, b});
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int t;
    t = 0;
    while ((exp_q.size() != 0 || txq_nonempty) && t < 100) begin
      @(negedge clk);
      t++;
    end
    chk(t < 100, req, exp_q.size(), 0);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    // R1: reset state
    chk(!sh_valid && !txq_pop && !xoff_outstanding && !last_is_xoff, "R1 reset",
        {sh_valid, txq_pop, xoff_outstanding, last_is_xoff}, 0);
    rst_n = 1'b1;
    step(2);
    chk(!sh_valid && !xoff_outstanding, "R1 after release", {sh_valid, xoff_outstanding}, 0);

    // R6: plain pass-through of queued bytes
    push_q(8'hA1); push_q(8'hB2);
    expect_item(1'b0, 8'hA1); expect_item(1'b0, 8'hB2);
    step(1);
    chk(sh_valid && sh_data == 8'hA1 && !txq_pop, "R6 offer head, no pop w/o ready",
        sh_data, 8'hA1);
    sh_ready = 1'b1;
    drain("R6 drain");

    // R2/R5: stop character takes priority over a queued byte
    sh_ready = 1'b0;
    push_q(8'hC3);
    rx_level = 5'd13;
    step(2);
    chk(sh_valid && sh_is_flow && sh_data == 8'h13 && !txq_pop, "R2/R5 xoff offered first",
        {sh_is_flow, sh_data}, 9'h113);
    expect_item(1'b1, 8'h13); expect_item(1'b0, 8'hC3);
    sh_ready = 1'b1;
    drain("R5 drain");
    chk(xoff_outstanding && last_is_xoff, "R2 record set", {xoff_outstanding, last_is_xoff}, 3);

    // R8: no second stop while outstanding
    push_q(8'hD4);
    expect_item(1'b0, 8'hD4);
    drain("R8 drain");
    step(3);
    chk(!sh_valid, "R8 no repeat xoff", sh_valid, 0);

    // R4: band edges
    rx_level = 5'd8;
    step(3);
    chk(!sh_valid, "R4 level 8 quiet", sh_valid, 0);
    rx_level = 5'd12;
    step(3);
    chk(!sh_valid && xoff_outstanding, "R4 level 12 quiet", sh_valid, 0);

    // R7: resume withdrawn when level returns into band
    sh_ready = 1'b0;
    rx_level = 5'd7;
    step(2);
    chk(sh_valid && sh_is_flow && sh_data == 8'h11, "R3 xon offered", sh_data, 8'h11);
    rx_level = 5'd9;
    step(2);
    chk(!sh_valid, "R7 xon withdrawn", sh_valid, 0);
    sh_ready = 1'b1;
    step(4);
    chk(xoff_outstanding, "R7 record kept", xoff_outstanding, 1);

    // R3: resume sent
    sh_ready = 1'b0;
    rx_level = 5'd5;
    step(2);
    expect_item(1'b1, 8'h11);
    sh_ready = 1'b1;
    drain("R3 drain");
    chk(!xoff_outstanding && !last_is_xoff, "R3 record cleared",
        {xoff_outstanding, last_is_xoff}, 0);

    // R8: no resume without an outstanding stop
    rx_level = 5'd3;
    step(4);
    chk(!sh_valid, "R8 no xon unowed", sh_valid, 0);

    // R7: stop withdrawn
    sh_ready = 1'b0;
    rx_level = 5'd13;
    step(2);
    chk(sh_valid && sh_is_flow, "R2 xoff offered again", sh_is_flow, 1);
    rx_level = 5'd10;
    step(2);
    chk(!sh_valid, "R7 xoff withdrawn", sh_valid, 0);
    sh_ready = 1'b1;
    step(4);
    chk(!xoff_outstanding, "R7 no record", xoff_outstanding, 0);

    // R10: code taken from the input at offer time
    xoff_code = 8'h5A;
    rx_level = 5'd14;
    expect_item(1'b1, 8'h5A);
    step(2);
    drain("R10 drain");
    chk(xoff_outstanding, "R10 record set", xoff_outstanding, 1);

    // R9: mode off clears record, no resume, status kept
    auto_rx_en = 1'b0;
    step(1);
    chk(!xoff_outstanding && last_is_xoff, "R9 cleared, status kept",
        {xoff_outstanding, last_is_xoff}, 1);
    rx_level = 5'd2;
    step(4);
    chk(!sh_valid, "R9 no xon on mode off", sh_valid, 0);
    rx_level = 5'd15;
    step(4);
    chk(!sh_valid, "R9 no xoff while off", sh_valid, 0);
    expect_item(1'b1, 8'h5A);
    auto_rx_en = 1'b1;
    drain("R9 re-enable drain");
    step(2);
    chk(xoff_outstanding, "R9 xoff after re-enable", xoff_outstanding, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule